// File: doc/BRIEF.md
# Programmable Multi-Line Video Delay

This block holds a bank of eight 8-bit delay lines that are chained one after another. A raster-scanned pixel stream goes into the head of the chain. Each line delays its input by a programmable number of shift cycles, and that number is normally set to the count of pixels per video line. The taps then present one column of vertically adjacent pixels from successive lines, which is the form a 2-D image filter needs. Each line is a circular buffer. All lines share one read/write pointer, and that pointer wraps at the programmed depth.

An 8-bit control word is captured while an active-low write strobe is asserted. The low seven bits set the length code, and the top bit chooses what a hold does to the outputs: it either blanks them to zero or freezes them. Three active-low controls act on the input side:
- a hold (shift-enable low) stops the clock for all storage;
- a flush puts zeros in place of the pixel bus;
- a broadcast writes the head pixel into every line at once, in place of the cascade.

An elaboration parameter selects paired operation. In that mode adjacent lines act as one line of twice the length, and only every second tap is exposed.

Top module: `vid_line_bank`

## Requirements
- R1: With length code L, each line delays its own input by D = 4·L + 8 shift cycles. Line k (k > 0) takes its input from line k−1, so tap k shows the pixel that entered (k+1)·D shift cycles earlier.
- R2: With PAIRED = 1 the block has four outputs. Output j (bits 8j+7:8j) carries line 2j+1, so each output adds 2·D = 8·L + 16 shift cycles over the one before it.
- R3: A clock edge with ctl_wr_n low loads L from ctl_i[6:0] and the hold-mode bit from ctl_i[7]. The new L applies from the next edge. If L changed, the pointer restarts at zero, and tap k is valid again once (k+1)·D shift cycles have passed since the write.
- R4: Storage, pointer and taps advance only on edges where run_shift is high. Pixel, flush and broadcast inputs present while run_shift is low have no effect.
- R5: While run_shift is low and the hold-mode bit is 0, every output reads zero in that same cycle. The stored taps reappear once run_shift returns high.
- R6: While run_shift is low and the hold-mode bit is 1, the outputs keep their last values.
- R7: On a shift edge with flush_n low, a zero enters the chain in place of pix_i.
- R8: On a shift edge with bcast_n low, the head value (after any flush) is written into every line at once. That value appears on each tap D shift cycles later.
- R9: Synchronous reset clears all taps to zero, sets L = 1 (D = 12) and sets the hold-mode bit to 1.
- R10: L = 127 gives D = 516, and L = 1 gives D = 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_i | input | PIX_W | Incoming pixel |
| ctl_i | input | LEN_W+1 | Control word: length code in the low bits, hold-mode bit on top |
| ctl_wr_n | input | 1 | Active-low control write strobe |
| run_shift | input | 1 | High: shift on this edge; low: hold |
| flush_n | input | 1 | Active-low: put zero in place of the pixel |
| bcast_n | input | 1 | Active-low: write the head value into all lines |
| taps_o | output | OUTS·PIX_W | Tap outputs, tap 0 in the low byte; OUTS = LINES, or LINES/2 when paired |

## Verification
A pointer that wraps one slot early or late shows up as a constant shift of the whole column. Tap 0 goes wrong D+1 shifts after the fault, and each later tap goes wrong one line period after the one before it. A wrong chain link, or a wrong broadcast or flush mux, corrupts only the taps downstream of it, and the error appears exactly D shifts after the first pixel that the fault affects. A stuck hold-mode bit or a wrong hold gate is visible on the outputs in the first hold cycle. The bench therefore compares every exposed tap against an ideal delay model on every clock, in both the single and the paired configuration.

// File: rtl/vlb_pkg.sv
package vlb_pkg;
   // number of shift stages for a given length code
   function automatic int line_depth(input int len, input int step, input int base);
      return len * step + base;
   endfunction
endpackage

// File: rtl/vlb_ctrl.sv
module vlb_ctrl #(
   parameter int LEN_W = 7,
   parameter int STEP  = 4,
   parameter int BASE  = 8,
   parameter int PTR_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_n,
   input  logic [LEN_W-1:0] ctl_len,
   input  logic             ctl_mode,
   input  logic             shift_en,
   output logic [LEN_W-1:0] len_q,
   output logic             freeze_q,
   output logic [PTR_W-1:0] ptr_q,
   output logic [PTR_W-1:0] ptr_last
);
   logic len_change;

   assign ptr_last   = PTR_W'(len_q) * PTR_W'(STEP) + PTR_W'(BASE - 1);
   assign len_change = !wr_n && (ctl_len != len_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         len_q    <= LEN_W'(1);
         freeze_q <= 1'b1;
         ptr_q    <= '0;
      end else begin
         if (!wr_n) begin
            len_q    <= ctl_len;
            freeze_q <= ctl_mode;
         end
         if (len_change)
            ptr_q <= '0;
         else if (shift_en)
            ptr_q <= (ptr_q == ptr_last) ? '0 : ptr_q + PTR_W'(1);
      end
   end
endmodule

// File: rtl/vlb_line.sv
module vlb_line #(
   parameter int PIX_W = 8,
   parameter int DEPTH = 516,
   parameter int PTR_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic [PTR_W-1:0] ptr,
   input  logic [PIX_W-1:0] wdata,
   output logic [PIX_W-1:0] rdata,
   output logic [PIX_W-1:0] tap_q
);
   logic [PIX_W-1:0] mem [DEPTH];

   assign rdata = mem[ptr];

   always_ff @(posedge clk)
      if (shift_en) mem[ptr] <= wdata;

   always_ff @(posedge clk) begin
      if (rst)           tap_q <= '0;
      else if (shift_en) tap_q <= rdata;
   end
endmodule

// File: rtl/vlb_tapout.sv
module vlb_tapout #(
   parameter int LINES  = 8,
   parameter int PIX_W  = 8,
   parameter bit PAIRED = 1'b0,
   parameter int OUTS   = 8
) (
   input  logic [LINES*PIX_W-1:0] tap_flat,
   input  logic                   blank,
   output logic [OUTS*PIX_W-1:0]  taps_o
);
   for (genvar j = 0; j < OUTS; j++) begin : g_out
      if (PAIRED) begin : g_pair
         assign taps_o[j*PIX_W +: PIX_W] =
            blank ? '0 : tap_flat[(2*j+1)*PIX_W +: PIX_W];
      end else begin : g_single
         assign taps_o[j*PIX_W +: PIX_W] =
            blank ? '0 : tap_flat[j*PIX_W +: PIX_W];
      end
   end
endmodule

// File: rtl/vid_line_bank.sv
module vid_line_bank #(
   parameter int LINES  = 8,
   parameter int PIX_W  = 8,
   parameter int LEN_W  = 7,
   parameter int STEP   = 4,
   parameter int BASE   = 8,
   parameter bit PAIRED = 1'b0
) (
   input  logic                                         clk,
   input  logic                                         rst,
   input  logic [PIX_W-1:0]                             pix_i,
   input  logic [LEN_W:0]                               ctl_i,
   input  logic                                         ctl_wr_n,
   input  logic                                         run_shift,
   input  logic                                         flush_n,
   input  logic                                         bcast_n,
   output logic [(PAIRED ? LINES/2 : LINES)*PIX_W-1:0]  taps_o
);
   import vlb_pkg::*;

   localparam int MAX_DEPTH = line_depth(2**LEN_W - 1, STEP, BASE);
   localparam int PTR_W     = $clog2(MAX_DEPTH);
   localparam int OUTS      = PAIRED ? LINES/2 : LINES;

   if (LINES < 1 || PIX_W < 1 || LEN_W < 1 || STEP < 1 || BASE < 2) begin : g_bad_dims
      $error("vid_line_bank: illegal dimension parameter");
   end
   if (PAIRED && (LINES % 2 != 0)) begin : g_bad_pair
      $error("vid_line_bank: paired mode needs an even line count");
   end

   logic [LEN_W-1:0]       len_q;
   logic                   freeze_q;
   logic [PTR_W-1:0]       ptr_q;
   logic [PTR_W-1:0]       ptr_last;
   logic [PIX_W-1:0]       head;
   logic [PIX_W-1:0]       rd   [LINES];
   logic [PIX_W-1:0]       wd   [LINES];
   logic [LINES*PIX_W-1:0] tap_flat;
   logic                   blank;

   assign head  = flush_n ? pix_i : '0;
   assign blank = !run_shift && !freeze_q;

   vlb_ctrl #(.LEN_W(LEN_W), .STEP(STEP), .BASE(BASE), .PTR_W(PTR_W)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .wr_n     (ctl_wr_n),
      .ctl_len  (ctl_i[LEN_W-1:0]),
      .ctl_mode (ctl_i[LEN_W]),
      .shift_en (run_shift),
      .len_q    (len_q),
      .freeze_q (freeze_q),
      .ptr_q    (ptr_q),
      .ptr_last (ptr_last)
   );

   for (genvar k = 0; k < LINES; k++) begin : g_line
      if (k == 0) begin : g_head
         assign wd[k] = head;
      end else begin : g_chain
         assign wd[k] = bcast_n ? rd[k-1] : head;
      end
      vlb_line #(.PIX_W(PIX_W), .DEPTH(MAX_DEPTH), .PTR_W(PTR_W)) u_line (
         .clk      (clk),
         .rst      (rst),
         .shift_en (run_shift),
         .ptr      (ptr_q),
         .wdata    (wd[k]),
         .rdata    (rd[k]),
         .tap_q    (tap_flat[k*PIX_W +: PIX_W])
      );
   end

   vlb_tapout #(.LINES(LINES), .PIX_W(PIX_W), .PAIRED(PAIRED), .OUTS(OUTS)) u_out (
      .tap_flat (tap_flat),
      .blank    (blank),
      .taps_o   (taps_o)
   );
endmodule

// File: rtl/vid_line_bank_chk.sv
module vid_line_bank_chk #(
   parameter int LINES = 8,
   parameter int PIX_W = 8,
   parameter int LEN_W = 7,
   parameter int PTR_W = 10,
   parameter int OUT_W = 64
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   run_shift,
   input logic                   ctl_wr_n,
   input logic [LEN_W:0]         ctl_i,
   input logic [OUT_W-1:0]       taps_o,
   input logic [LEN_W-1:0]       len_q,
   input logic                   freeze_q,
   input logic [PTR_W-1:0]       ptr_q,
   input logic [PTR_W-1:0]       ptr_last,
   input logic [LINES*PIX_W-1:0] tap_flat
);
   // R1: the shared pointer never leaves the programmed ring
   p_ptr_in_ring_r1: assert property (@(posedge clk) disable iff (rst)
      ptr_q <= ptr_last);

   // R3: a write strobe loads both control fields
   p_ctl_load_r3: assert property (@(posedge clk) disable iff (rst)
      !ctl_wr_n |=> (len_q == $past(ctl_i[LEN_W-1:0])) && (freeze_q == $past(ctl_i[LEN_W])));

   // R3: a changed length restarts the pointer
   p_ptr_restart_r3: assert property (@(posedge clk) disable iff (rst)
      (!ctl_wr_n && ctl_i[LEN_W-1:0] != len_q) |=> ptr_q == '0);

   // R4: a hold edge leaves taps and pointer untouched
   p_hold_state_r4: assert property (@(posedge clk) disable iff (rst)
      (!run_shift && ctl_wr_n) |=> ($stable(tap_flat) && $stable(ptr_q)));

   // R5: blanking hold drives zero on every output
   p_blank_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (!run_shift && !freeze_q) |-> taps_o == '0);

   // R6: freezing hold keeps the outputs steady
   p_freeze_keep_r6: assert property (@(posedge clk) disable iff (rst)
      (!run_shift && ctl_wr_n && freeze_q ##1 !run_shift) |-> $stable(taps_o));
endmodule

bind vid_line_bank vid_line_bank_chk #(
   .LINES(LINES), .PIX_W(PIX_W), .LEN_W(LEN_W), .PTR_W(PTR_W),
   .OUT_W((PAIRED ? LINES/2 : LINES)*PIX_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .run_shift (run_shift),
   .ctl_wr_n  (ctl_wr_n),
   .ctl_i     (ctl_i),
   .taps_o    (taps_o),
   .len_q     (len_q),
   .freeze_q  (freeze_q),
   .ptr_q     (ptr_q),
   .ptr_last  (ptr_last),
   .tap_flat  (tap_flat)
);

// File: tb/vid_line_bank_test.sv
module vid_line_bank_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  pix = '0;
   logic [7:0]  ctl = '0;
   logic        wr_n = 1'b1;
   logic        run_s = 1'b0;
   logic        flush_n = 1'b1;
   logic        bcast_n = 1'b1;
   logic [63:0] taps;
   logic [31:0] taps_p;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   string tag = "R9";

   // ideal-delay reference: history of pixels entering the head
   int unsigned hp [16384];
   bit          hb [16384];
   int n = 0;
   int start = 0;
   int len = 1;
   bit mode = 1'b1;

   always #2 clk = ~clk;

   vid_line_bank uut (
      .clk(clk), .rst(rst), .pix_i(pix), .ctl_i(ctl), .ctl_wr_n(wr_n),
      .run_shift(run_s), .flush_n(flush_n), .bcast_n(bcast_n), .taps_o(taps));

   vid_line_bank #(.PAIRED(1'b1)) uut_pair (
      .clk(clk), .rst(rst), .pix_i(pix), .ctl_i(ctl), .ctl_wr_n(wr_n),
      .run_shift(run_s), .flush_n(flush_n), .bcast_n(bcast_n), .taps_o(taps_p));

   // value of line k's tap after n shifts, or -1 when not yet refilled
   function automatic int model_tap(input int k);
      int d = 4*len + 8;
      int m = n - 1 - d;
      int kk = k;
      while (1) begin
         if (m < start) return -1;
         if (kk == 0 || hb[m]) return int'(hp[m]);
         m -= d;
         kk--;
      end
      return -1;
   endfunction

   task automatic cmp(input string t, input int lane, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         fails++;
         $display("FAIL %s tap %0d: actual %0h expected %0h (shift %0d)", t, lane, act, exp_v, n);
      end
   endtask

   task automatic compare();
      bit blank = !run_s && !mode;
      for (int k = 0; k < 8; k++) begin
         int e = blank ? 0 : model_tap(k);
         if (e >= 0) cmp(tag, k, int'(taps[k*8 +: 8]), e);
      end
      for (int j = 0; j < 4; j++) begin
         int e = blank ? 0 : model_tap(2*j+1);
         if (e >= 0) cmp({tag, " R2 paired"}, j, int'(taps_p[j*8 +: 8]), e);
      end
   endtask

   task automatic step(input logic [7:0] p, input bit run, input bit fl, input bit bc);
      @(negedge clk);
      pix = p; run_s = run; flush_n = fl; bcast_n = bc; wr_n = 1'b1;
      @(posedge clk);
      if (run) begin
         hp[n] = fl ? p : 8'd0;
         hb[n] = !bc;
         n++;
      end
      #1 compare();
   endtask

   task automatic write_ctl(input int l, input bit m);
      @(negedge clk);
      wr_n = 1'b0; ctl = {m, 7'(l)}; run_s = 1'b0; flush_n = 1'b1; bcast_n = 1'b1;
      @(posedge clk);
      if (l != len) start = n;
      len = l;
      mode = m;
      #1 compare();
   endtask

   task automatic stream(input int cnt);
      for (int i = 0; i < cnt; i++) step(8'($urandom), 1'b1, 1'b1, 1'b1);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      // R9: all taps clear after reset
      #1 cmp("R9 reset", 0, int'(taps), 0);
      cmp("R9 reset paired", 0, int'(taps_p), 0);

      // R9/R10: default length code 1, twelve-stage lines; R1 cascade
      tag = "R1 R9 R10 default";
      stream(120);

      // R3: change the length and let the lines refill
      tag = "R1 R3 length 5";
      write_ctl(5, 1'b1);
      stream(280);

      // R4/R6: freeze hold, pixels during hold are ignored
      tag = "R4 R6 freeze hold";
      for (int i = 0; i < 9; i++) step(8'($urandom), 1'b0, i[0], i[1]);
      stream(60);

      // R5: blanking hold, then the stored taps return
      tag = "R5 blank hold";
      write_ctl(5, 1'b0);
      stream(30);
      for (int i = 0; i < 7; i++) step(8'($urandom), 1'b0, 1'b1, 1'b1);
      stream(40);
      write_ctl(5, 1'b1);

      // R7: a flush window inserts zeros
      tag = "R7 flush";
      for (int i = 0; i < 70; i++) step(8'($urandom), 1'b1, !(i >= 15 && i < 40), 1'b1);
      stream(260);

      // R8: broadcast window fills every line at once
      tag = "R8 broadcast";
      for (int i = 0; i < 60; i++) step(8'($urandom), 1'b1, !(i >= 30 && i < 33), !(i >= 10 && i < 25));
      stream(260);

      // R10: longest line, 516 stages, with a hold in the middle
      tag = "R10 length 127";
      write_ctl(127, 1'b1);
      stream(2000);
      for (int i = 0; i < 5; i++) step(8'($urandom), 1'b0, 1'b1, 1'b1);
      stream(2300);

      // R3: shrink back down
      tag = "R3 length 2";
      write_ctl(2, 1'b1);
      stream(200);

      finish_run();
   end
endmodule